// File: doc/BRIEF.md
# Compare and Assert Trap Unit

This block evaluates one relation between two 32-bit operands per request and produces its outcome one clock later. In compare mode the outcome is a Boolean word bound for a destination register. In assert mode no register is written. A true condition lets execution carry on silently, and a false one raises a trap. The trap vector is the 8-bit destination field of the instruction.

Assert mode also applies a privilege check. Trap numbers below 64 belong to supervisor code. A user-mode assert that names one of them is refused with a fixed protection-violation vector, and this happens whatever the condition evaluates to. A system call is an assert of a relation that is always false, with the service number in the trap field. The relations are equality, inequality, signed and unsigned ordering, and a byte-match test. The byte-match test reports whether any byte of operand A equals the low byte of operand B.

Top module: `cmpAssertUnit`

## Requirements
- R1: `resValid`, `trapReq`, `trapVector` and `result` are registered. They reflect a request presented with `inValid` high exactly one clock later. In a cycle after which no request was presented, all four are zero.
- R2: The opcode encodings are 0 EQ, 1 NE, 2 signed LT, 3 signed LE, 4 signed GT, 5 signed GE, 6 unsigned LT, 7 unsigned LE, 8 unsigned GT and 9 unsigned GE. Each relation is A versus B.
- R3: Opcode 10 is byte-match. It is true when any of the four bytes of A equals bits 7:0 of B.
- R4: In compare mode (`assertMode` = 0), `resValid` is 1 and `trapReq` is 0. `result` is 0x80000000 for true and 0x00000000 for false.
- R5: In assert mode, `resValid` stays 0. A true condition with no privilege fault gives `trapReq` = 0.
- R6: In assert mode, a false condition with no privilege fault gives `trapReq` = 1 and sets `trapVector` equal to the request's `trapField`.
- R7: In assert mode with `userMode` = 1 and `trapField` < 64, the unit gives `trapReq` = 1 and `trapVector` = 0x05, whether the condition is true or false.
- R8: With `userMode` = 0, any trap number, including 0 to 63, follows R5/R6. With `userMode` = 1 and `trapField` ≥ 64, it also follows R5/R6.
- R9: Opcodes 11 to 15 always evaluate false. In compare mode they give a zero result, and in assert mode they always trap, which serves as a system call.
- R10: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| assertMode | input | 1 | 1 = assert, 0 = compare |
| opcode | input | 4 | Relation select |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| trapField | input | 8 | Destination field, used as trap number |
| userMode | input | 1 | 1 = user, 0 = supervisor |
| resValid | output | 1 | Result word valid |
| result | output | 32 | Boolean result word |
| trapReq | output | 1 | Trap request strobe |
| trapVector | output | 8 | Trap number requested |

## Verification
On every cycle, the assertions check the following:
- the one-cycle strobe timing;
- that assert mode never writes a result;
- that compare mode never traps;
- that a result is never written and a trap raised in the same cycle;
- the two legal Boolean encodings;
- the precedence of the protection vector.

Only the bench's sweeps can show whether each relation is arithmetically correct. That covers the signed versus unsigned ordering at the sign boundary and which byte lane matched. It also covers whether an assertion failure carries the exact trap number supplied.

// File: rtl/cmp_assert_pkg.sv
package cmp_assert_pkg;
  typedef enum logic [1:0] {KIND_NONE, KIND_EQ, KIND_LT, KIND_BYTE} cmpKind_e;

  typedef struct packed {
    cmpKind_e kind;
    logic     signedCmp;
    logic     swapOps;
    logic     invert;
    logic     loadResult;
  } cmpCtrl_t;

  localparam logic [3:0] OP_EQ   = 4'd0;
  localparam logic [3:0] OP_NE   = 4'd1;
  localparam logic [3:0] OP_LTS  = 4'd2;
  localparam logic [3:0] OP_LES  = 4'd3;
  localparam logic [3:0] OP_GTS  = 4'd4;
  localparam logic [3:0] OP_GES  = 4'd5;
  localparam logic [3:0] OP_LTU  = 4'd6;
  localparam logic [3:0] OP_LEU  = 4'd7;
  localparam logic [3:0] OP_GTU  = 4'd8;
  localparam logic [3:0] OP_GEU  = 4'd9;
  localparam logic [3:0] OP_BYTE = 4'd10;
endpackage

// File: rtl/cmpDatapath.sv
module cmpDatapath
  import cmp_assert_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              condTrue,
  output logic [DATA_W-1:0] result
);
  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] TRUE_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] lhs, rhs;
  logic [LANES-1:0]  laneHit;
  logic              rawCond;

  assign lhs = ctrl.swapOps ? opB : opA;
  assign rhs = ctrl.swapOps ? opA : opB;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneHit[i] = (opA[8*i +: 8] == opB[7:0]);
  end

  always_comb begin
    unique case (ctrl.kind)
      KIND_EQ:   rawCond = (lhs == rhs);
      KIND_LT:   rawCond = ctrl.signedCmp ? ($signed(lhs) < $signed(rhs)) : (lhs < rhs);
      KIND_BYTE: rawCond = |laneHit;
      default:   rawCond = 1'b0;
    endcase
    condTrue = (ctrl.kind == KIND_NONE) ? 1'b0 : (rawCond ^ ctrl.invert);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                result <= '0;
    else if (ctrl.loadResult) result <= condTrue ? TRUE_WORD : '0;
    else                      result <= '0;
  end
endmodule

// File: rtl/cmpControl.sv
module cmpControl
  import cmp_assert_pkg::*;
#(
  parameter int              TRAP_W     = 8,
  parameter int              PRIV_LIMIT = 64,
  parameter logic [TRAP_W-1:0] PROT_VEC = 8'd5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              assertMode,
  input  logic [3:0]        opcode,
  input  logic [TRAP_W-1:0] trapField,
  input  logic              userMode,
  input  logic              condTrue,
  output cmpCtrl_t          ctrl,
  output logic              resValid,
  output logic              trapReq,
  output logic [TRAP_W-1:0] trapVector
);
  localparam logic [TRAP_W-1:0] LIMIT = TRAP_W'(PRIV_LIMIT);

  logic isAssert, privFault, assertFail;

  always_comb begin
    ctrl = '{kind: KIND_NONE, signedCmp: 1'b0, swapOps: 1'b0, invert: 1'b0, loadResult: 1'b0};
    unique case (opcode)
      OP_EQ:   ctrl.kind = KIND_EQ;
      OP_NE:   begin ctrl.kind = KIND_EQ; ctrl.invert = 1'b1; end
      OP_LTS:  begin ctrl.kind = KIND_LT; ctrl.signedCmp = 1'b1; end
      OP_LES:  begin ctrl.kind = KIND_LT; ctrl.signedCmp = 1'b1; ctrl.swapOps = 1'b1; ctrl.invert = 1'b1; end
      OP_GTS:  begin ctrl.kind = KIND_LT; ctrl.signedCmp = 1'b1; ctrl.swapOps = 1'b1; end
      OP_GES:  begin ctrl.kind = KIND_LT; ctrl.signedCmp = 1'b1; ctrl.invert = 1'b1; end
      OP_LTU:  ctrl.kind = KIND_LT;
      OP_LEU:  begin ctrl.kind = KIND_LT; ctrl.swapOps = 1'b1; ctrl.invert = 1'b1; end
      OP_GTU:  begin ctrl.kind = KIND_LT; ctrl.swapOps = 1'b1; end
      OP_GEU:  begin ctrl.kind = KIND_LT; ctrl.invert = 1'b1; end
      OP_BYTE: ctrl.kind = KIND_BYTE;
      default: ctrl.kind = KIND_NONE;
    endcase
    ctrl.loadResult = inValid & ~assertMode;
  end

  assign isAssert   = inValid & assertMode;
  assign privFault  = isAssert & userMode & (trapField < LIMIT);
  assign assertFail = isAssert & ~condTrue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      trapReq    <= 1'b0;
      trapVector <= '0;
    end else begin
      resValid <= ctrl.loadResult;
      trapReq  <= privFault | assertFail;
      if (privFault)       trapVector <= PROT_VEC;
      else if (assertFail) trapVector <= trapField;
      else                 trapVector <= '0;
    end
  end
endmodule

// File: rtl/cmpAssertUnit.sv
module cmpAssertUnit
  import cmp_assert_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                TRAP_W     = 8,
  parameter int                PRIV_LIMIT = 64,
  parameter logic [TRAP_W-1:0] PROT_VEC   = 8'd5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              assertMode,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [TRAP_W-1:0] trapField,
  input  logic              userMode,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              trapReq,
  output logic [TRAP_W-1:0] trapVector
);
  cmpCtrl_t ctrl;
  logic     condTrue;

  cmpControl #(.TRAP_W(TRAP_W), .PRIV_LIMIT(PRIV_LIMIT), .PROT_VEC(PROT_VEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .assertMode(assertMode),
    .opcode(opcode), .trapField(trapField), .userMode(userMode),
    .condTrue(condTrue), .ctrl(ctrl), .resValid(resValid),
    .trapReq(trapReq), .trapVector(trapVector)
  );

  cmpDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .condTrue(condTrue), .result(result)
  );
endmodule

// File: rtl/cmpAssertChecker.sv
module cmpAssertChecker #(
  parameter int                DATA_W     = 32,
  parameter int                TRAP_W     = 8,
  parameter int                PRIV_LIMIT = 64,
  parameter logic [TRAP_W-1:0] PROT_VEC   = 8'd5
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              assertMode,
  input logic [TRAP_W-1:0] trapField,
  input logic              userMode,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic              trapReq,
  input logic [TRAP_W-1:0] trapVector
);
  localparam logic [DATA_W-1:0] TRUE_WORD = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [TRAP_W-1:0] LIMIT = TRAP_W'(PRIV_LIMIT);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!resValid && !trapReq && result == '0));

  p_cmp_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !assertMode) |=> (resValid && !trapReq));

  p_bool_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (result == TRUE_WORD || result == '0));

  p_assert_nowrite_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && assertMode) |=> !resValid);

  p_prot_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && assertMode && userMode && trapField < LIMIT) |=> (trapReq && trapVector == PROT_VEC));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && trapReq));

  p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |-> trapVector == '0);
endmodule

bind cmpAssertUnit cmpAssertChecker #(
  .DATA_W(DATA_W), .TRAP_W(TRAP_W), .PRIV_LIMIT(PRIV_LIMIT), .PROT_VEC(PROT_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .assertMode(assertMode),
  .trapField(trapField), .userMode(userMode), .resValid(resValid),
  .result(result), .trapReq(trapReq), .trapVector(trapVector)
);

// File: tb/cmpAssertUnit_test.sv
module cmpAssertUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        assertMode = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [7:0]  trapField = '0;
  logic        userMode = 1'b0;
  logic        resValid;
  logic [31:0] result;
  logic        trapReq;
  logic [7:0]  trapVector;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cmpAssertUnit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .assertMode(assertMode),
    .opcode(opcode), .opA(opA), .opB(opB), .trapField(trapField),
    .userMode(userMode), .resValid(resValid), .result(result),
    .trapReq(trapReq), .trapVector(trapVector)
  );

  logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h12AB_34CD, 32'h0000_00AB, 32'h5555_55CD};
  logic [7:0]  traps [4] = '{8'd0, 8'd63, 8'd64, 8'd255};

  function automatic bit expCond(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return $signed(a) <  $signed(b);
      4'd3: return $signed(a) <= $signed(b);
      4'd4: return $signed(a) >  $signed(b);
      4'd5: return $signed(a) >= $signed(b);
      4'd6: return a <  b;
      4'd7: return a <= b;
      4'd8: return a >  b;
      4'd9: return a >= b;
      4'd10: return (a[7:0] == b[7:0]) || (a[15:8] == b[7:0]) ||
                    (a[23:16] == b[7:0]) || (a[31:24] == b[7:0]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag, input logic eV, input logic [31:0] eR,
                              input logic eT, input logic [7:0] eVec);
    check(tag, {resValid, result, trapReq, trapVector}, {eV, eR, eT, eVec});
  endtask

  task automatic issue(input logic m, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [7:0] tf, input logic u);
    @(negedge clk);
    inValid = 1'b1; assertMode = m; opcode = op; opA = a; opB = b; trapField = tf; userMode = u;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit c;
    string tag;
    repeat (3) @(negedge clk);
    checkOutputs("R10 reset", 1'b0, 32'h0, 1'b0, 8'h0);
    rstN = 1'b1;

    // Compare mode sweep: R2, R3, R4, R9
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          c = expCond(4'(op), vals[i], vals[j]);
          tag = (op == 10) ? "R3 byte-match" : (op > 10) ? "R9 reserved" : "R2 relation";
          issue(1'b0, 4'(op), vals[i], vals[j], 8'hA5, 1'b1);
          checkOutputs({tag, " / R4 compare word"}, 1'b1, c ? 32'h8000_0000 : 32'h0, 1'b0, 8'h0);
        end
      end
    end
    @(negedge clk);
    checkOutputs("R1 idle after request", 1'b0, 32'h0, 1'b0, 8'h0);

    // Assert mode sweep: R5, R6, R7, R8, R9
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int u = 0; u < 2; u++) begin
            for (int t = 0; t < 4; t++) begin
              c = expCond(4'(op), vals[i], vals[j]);
              issue(1'b1, 4'(op), vals[i], vals[j], traps[t], u[0]);
              if (u == 1 && traps[t] < 8'd64)
                checkOutputs("R7 protection", 1'b0, 32'h0, 1'b1, 8'h05);
              else if (c)
                checkOutputs(u == 0 ? "R8 supervisor pass / R5" : "R5 assert pass",
                             1'b0, 32'h0, 1'b0, 8'h0);
              else
                checkOutputs(op > 10 ? "R9 system call / R6" :
                             (u == 0 ? "R8 supervisor trap / R6" : "R6 assert trap"),
                             1'b0, 32'h0, 1'b1, traps[t]);
            end
          end
        end
      end
    end

    // R1 latency: back-to-back requests, then a gap
    @(negedge clk);
    inValid = 1'b1; assertMode = 1'b0; opcode = 4'd0; opA = 32'h7; opB = 32'h7;
    @(negedge clk);
    checkOutputs("R1 first of pair", 1'b1, 32'h8000_0000, 1'b0, 8'h0);
    assertMode = 1'b1; trapField = 8'd200; userMode = 1'b1; opB = 32'h8;
    @(negedge clk);
    inValid = 1'b0;
    checkOutputs("R1 second of pair", 1'b0, 32'h0, 1'b1, 8'd200);
    @(negedge clk);
    checkOutputs("R1 idle", 1'b0, 32'h0, 1'b0, 8'h0);

    // R10 reset mid-operation
    inValid = 1'b1; assertMode = 1'b0; opA = 32'h1; opB = 32'h1; opcode = 4'd0; rstN = 1'b0;
    @(negedge clk);
    checkOutputs("R10 reset holds", 1'b0, 32'h0, 1'b0, 8'h0);
    inValid = 1'b0; rstN = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule